// File: doc/BRIEF.md
# Reversible-Gate Latch Register File

This block is a small register file of 32 eight-bit registers whose every logic function is composed from three reversible primitives: a controlled-NOT, a controlled-swap and a double-controlled-NOT. Each primitive has as many outputs as inputs. Constant inputs are tied off explicitly, and outputs that carry no useful result are brought out on wires marked as garbage rather than dropped inside the primitive.

The file has no clock. A single mode flag decides what the whole file does. With the flag high, the file is in read mode: two independent read ports each show the register picked by their own 5-bit select. With the flag low, the file is in write mode: the register named by the write select becomes a transparent latch that follows the write data, and both read ports drive zero. The value on the write data input when the flag returns high is the one the register keeps.

Storage is one level-sensitive latch per bit. A decoder tree turns the write select into one-hot lines, and each line is gated by the write enable. Each read port is a five-level tree of controlled-swap selectors followed by an enable gate.

Top module: `rev_latch_regfile`

## Requirements
- R1: The file holds 32 registers of 8 bits. A write in write mode lands in the register whose index equals `wr_sel`, read as an unsigned binary number.
- R2: With `rw_mode` = 1, `rd_data_a` equals the register indexed by `rd_sel_a` and `rd_data_b` equals the register indexed by `rd_sel_b`. The two ports are independent, and equal selects give equal data.
- R3: With `rw_mode` = 0, both `rd_data_a` and `rd_data_b` are 8'h00.
- R4: While `rw_mode` = 0, the selected register follows `wr_data`. The value present when `rw_mode` rises is kept.
- R5: With `rw_mode` = 1, no register changes, whatever `wr_data` and `wr_sel` do.
- R6: A write to one register leaves all other registers unchanged.
- R7: Each primitive is a bijection with this mapping. Controlled-NOT: (a,b) -> (a, a^b). Controlled-swap: (c,x,y) -> (c, c?y:x, c?x:y). Double-controlled-NOT: (a,b,c) -> (a, b, c^(a&b)).
- R8: Exactly one decoder line is active, and its index equals `wr_sel`. The gated write lines are all zero in read mode and equal the decoder lines in write mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rw_mode | input | 1 | 1 = read mode, 0 = write mode |
| wr_sel | input | 5 | Index of the register to write |
| wr_data | input | 8 | Data for the write |
| rd_sel_a | input | 5 | Register index for read port A |
| rd_sel_b | input | 5 | Register index for read port B |
| rd_data_a | output | 8 | Read port A data (zero in write mode) |
| rd_data_b | output | 8 | Read port B data (zero in write mode) |

## Verification
The assertions hold continuously on the decoder and the write gating: one active line that matches the write select, and silence in read mode. They also check that each read port shows the latch contents it selects and drives zero in write mode. Only the bench scenarios can show what a latch stores over time. That covers the last value taken when the mode flag rises, the values held while the write inputs toggle in read mode, and neighbours untouched by a write. The bench also sweeps every primitive across all of its input codes.

// File: rtl/rfx_pkg.sv
package rfx_pkg;

    // Next-state bundle of one storage bit: open the latch, and the value it takes.
    typedef struct packed {
        logic load;
        logic value;
    } cell_next_t;

endpackage

// File: rtl/rg_primitives.sv
// Reversible primitives. Each output set is a one-to-one function of the input set.

// Controlled-NOT: (a, b) -> (a, a ^ b)
module rg_cnot (
    input  logic a,
    input  logic b,
    output logic p,
    output logic q
);
    assign p = a;
    assign q = a ^ b;
endmodule

// Controlled-swap: c passes through, x and y trade places when c is 1
module rg_cswap (
    input  logic c,
    input  logic x,
    input  logic y,
    output logic p,
    output logic q,
    output logic r
);
    assign p = c;
    assign q = (c & y) | (~c & x);
    assign r = (c & x) | (~c & y);
endmodule

// Double-controlled-NOT: third line flips when both controls are 1
module rg_ccnot (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic p,
    output logic q,
    output logic r
);
    assign p = a;
    assign q = b;
    assign r = c ^ (a & b);
endmodule

// File: rtl/rfx_decoder.sv
// Binary-to-one-hot tree. The root is a controlled-NOT with a constant-1 target,
// and every further level splits each line with a controlled-swap whose y is 0.
module rfx_decoder #(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0]        sel,
    output logic [(1<<ADDR_W)-1:0]   line
);
    localparam int DEPTH = 1 << ADDR_W;

    // Heap layout: node k has children 2k (bit = 0) and 2k+1 (bit = 1)
    wire [2*DEPTH-1:2] node;
    wire [DEPTH-1:2]   unused_ctl;

    // The top select bit gives the two root lines: ~a at node 2, a at node 3
    rg_cnot u_root (
        .a (sel[ADDR_W-1]),
        .b (1'b1),
        .p (node[3]),
        .q (node[2])
    );

    for (genvar d = 1; d < ADDR_W; d++) begin : g_lvl
        for (genvar k = (1 << d); k < (2 << d); k++) begin : g_split
            rg_cswap u_split (
                .c (sel[ADDR_W-1-d]),
                .x (node[k]),
                .y (1'b0),
                .p (unused_ctl[k]),
                .q (node[2*k]),
                .r (node[2*k+1])
            );
        end
    end

    assign line = node[2*DEPTH-1:DEPTH];
endmodule

// File: rtl/rfx_latch_cell.sv
// One storage bit. A controlled-swap steers the data bit onto its third line
// while the gated enable is high, and a controlled-NOT with a constant-0 target
// forms the value. The level-sensitive store holds it while the enable is low.
module rfx_latch_cell
    import rfx_pkg::*;
(
    input  logic en,
    input  logic d,
    output logic q
);
    wire unused_ctl;
    wire unused_mid;
    wire unused_copy;
    wire steer;
    wire fwd;

    cell_next_t cell_d;
    logic       bit_q;

    rg_cswap u_steer (
        .c (en),
        .x (d),
        .y (1'b0),
        .p (unused_ctl),
        .q (unused_mid),
        .r (steer)
    );

    rg_cnot u_fan (
        .a (steer),
        .b (1'b0),
        .p (unused_copy),
        .q (fwd)
    );

    always_comb begin
        cell_d.load  = en;
        cell_d.value = fwd;
    end

    always_latch begin
        if (cell_d.load) begin
            bit_q <= cell_d.value;
        end
    end

    assign q = bit_q;
endmodule

// File: rtl/rfx_read_mux.sv
// One read port: per data bit, an ADDR_W-level tree of controlled-swap selectors.
// The root value is gated by the port enable through a double-controlled-NOT.
module rfx_read_mux #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] sel,
    input  logic [DATA_W-1:0] words [1<<ADDR_W],
    output logic [DATA_W-1:0] dout
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        wire [2*DEPTH-1:1] node;
        wire [DEPTH-1:1]   unused_ctl;
        wire [DEPTH-1:1]   unused_other;
        wire               unused_gate_a;
        wire               unused_gate_b;

        for (genvar i = 0; i < DEPTH; i++) begin : g_leaf
            assign node[DEPTH+i] = words[i][b];
        end

        // Depth d picks with select bit ADDR_W-1-d; the leaves use bit 0
        for (genvar d = 0; d < ADDR_W; d++) begin : g_lvl
            for (genvar k = (1 << d); k < (2 << d); k++) begin : g_pick
                rg_cswap u_pick (
                    .c (sel[ADDR_W-1-d]),
                    .x (node[2*k]),
                    .y (node[2*k+1]),
                    .p (unused_ctl[k]),
                    .q (node[k]),
                    .r (unused_other[k])
                );
            end
        end

        rg_ccnot u_gate (
            .a (en),
            .b (node[1]),
            .c (1'b0),
            .p (unused_gate_a),
            .q (unused_gate_b),
            .r (dout[b])
        );
    end
endmodule

// File: rtl/rev_latch_regfile.sv
// Clockless register file. rw_mode = 1 reads on two ports, rw_mode = 0 opens the
// latch row named by wr_sel.
module rev_latch_regfile #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              rw_mode,
    input  logic [ADDR_W-1:0] wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_sel_a,
    input  logic [ADDR_W-1:0] rd_sel_b,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b
);
    localparam int DEPTH = 1 << ADDR_W;

    wire                rd_a_en;
    wire                rd_b_en;
    wire                wr_en;
    wire                unused_ctl_b;
    wire [DEPTH-1:0]    dec_line;
    wire [DEPTH-1:0]    wr_gate;
    wire [DEPTH-1:0]    unused_gate_a;
    wire [DEPTH-1:0]    unused_gate_b;
    wire [DATA_W-1:0]   reg_q [DEPTH];

    // Mode split: first output copies the flag (read enable),
    // second output is its complement (write enable)
    rg_cnot u_mode_a (
        .a (rw_mode),
        .b (1'b1),
        .p (rd_a_en),
        .q (wr_en)
    );

    rg_cnot u_mode_b (
        .a (rw_mode),
        .b (1'b1),
        .p (rd_b_en),
        .q (unused_ctl_b)
    );

    rfx_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .sel  (wr_sel),
        .line (dec_line)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        rg_ccnot u_wgate (
            .a (wr_en),
            .b (dec_line[i]),
            .c (1'b0),
            .p (unused_gate_a[i]),
            .q (unused_gate_b[i]),
            .r (wr_gate[i])
        );

        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            rfx_latch_cell u_cell (
                .en (wr_gate[i]),
                .d  (wr_data[b]),
                .q  (reg_q[i][b])
            );
        end
    end

    rfx_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_a (
        .en    (rd_a_en),
        .sel   (rd_sel_a),
        .words (reg_q),
        .dout  (rd_data_a)
    );

    rfx_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_b (
        .en    (rd_b_en),
        .sel   (rd_sel_b),
        .words (reg_q),
        .dout  (rd_data_b)
    );
endmodule

// File: rtl/rfx_checker.sv
// Continuous checks. The block has no clock, so these are immediate assertions
// re-evaluated whenever any observed signal settles.
module rfx_checker #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input logic                    rw_mode,
    input logic [ADDR_W-1:0]       wr_sel,
    input logic [ADDR_W-1:0]       rd_sel_a,
    input logic [ADDR_W-1:0]       rd_sel_b,
    input logic [DATA_W-1:0]       rd_data_a,
    input logic [DATA_W-1:0]       rd_data_b,
    input logic [(1<<ADDR_W)-1:0]  dec_line,
    input logic [(1<<ADDR_W)-1:0]  wr_gate,
    input logic [DATA_W-1:0]       reg_q [1<<ADDR_W]
);
    always_comb begin
        a_r8_dec_onehot: assert ($countones(dec_line) == 1 && dec_line[wr_sel] == 1'b1)
            else $error("decoder line mismatch for select %0d", wr_sel);
        if (rw_mode) begin
            a_r8_gate_idle: assert (wr_gate == '0)
                else $error("write gate active in read mode");
            a_r2_port_a_data: assert (rd_data_a == reg_q[rd_sel_a])
                else $error("port A shows wrong register");
            a_r2_port_b_data: assert (rd_data_b == reg_q[rd_sel_b])
                else $error("port B shows wrong register");
            if (rd_sel_a == rd_sel_b) begin
                a_r2_same_select: assert (rd_data_a == rd_data_b)
                    else $error("ports disagree on one register");
            end
        end else begin
            a_r8_gate_follow: assert (wr_gate == dec_line)
                else $error("write gate differs from decoder");
            a_r3_port_a_zero: assert (rd_data_a == '0)
                else $error("port A not zero in write mode");
            a_r3_port_b_zero: assert (rd_data_b == '0)
                else $error("port B not zero in write mode");
        end
    end
endmodule

bind rev_latch_regfile rfx_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rfx_checker (
    .rw_mode   (rw_mode),
    .wr_sel    (wr_sel),
    .rd_sel_a  (rd_sel_a),
    .rd_sel_b  (rd_sel_b),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b),
    .dec_line  (dec_line),
    .wr_gate   (wr_gate),
    .reg_q     (reg_q)
);

// File: tb/test_rev_latch_regfile.sv
`timescale 1ns/1ps
module test_rev_latch_regfile;
    localparam int AW    = 5;
    localparam int DW    = 8;
    localparam int NREG  = 1 << AW;
    localparam int LIMIT = 200000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rw_mode  = 1'b0;
    logic [AW-1:0] wr_sel   = '0;
    logic [DW-1:0] wr_data  = '0;
    logic [AW-1:0] rd_sel_a = '0;
    logic [AW-1:0] rd_sel_b = '0;
    logic [DW-1:0] rd_data_a;
    logic [DW-1:0] rd_data_b;

    rev_latch_regfile #(.ADDR_W(AW), .DATA_W(DW)) i_rev_latch_regfile (
        .rw_mode   (rw_mode),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel_a  (rd_sel_a),
        .rd_sel_b  (rd_sel_b),
        .rd_data_a (rd_data_a),
        .rd_data_b (rd_data_b)
    );

    // Stand-alone primitives for the exhaustive sweep (R7)
    logic ca, cb, cp, cq;
    logic sc, sx, sy, sp, sq, sr;
    logic ta, tb, tc, tp, tq, tr;
    rg_cnot  i_cnot  (.a(ca), .b(cb), .p(cp), .q(cq));
    rg_cswap i_cswap (.c(sc), .x(sx), .y(sy), .p(sp), .q(sq), .r(sr));
    rg_ccnot i_ccnot (.a(ta), .b(tb), .c(tc), .p(tp), .q(tq), .r(tr));

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [DW-1:0] mem [NREG];
    logic [15:0]   exp_q [$];
    string         tag_q [$];
    logic [15:0]   mon_e;
    string         mon_t;

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Monitor: compares both read ports at the edge after each pushed item
    always @(posedge clk) begin
        if (exp_q.size() > 0) begin
            mon_e = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            check({rd_data_a, rd_data_b} == mon_e, mon_t, {rd_data_a, rd_data_b}, mon_e);
        end
    end

    task automatic do_read(input int a, input int b, input string tag);
        @(negedge clk);
        rd_sel_a = AW'(a);
        rd_sel_b = AW'(b);
        exp_q.push_back({mem[a], mem[b]});
        tag_q.push_back(tag);
    endtask

    // Write: set select and data in read mode, pulse write mode, return
    task automatic write_reg(input int idx, input logic [DW-1:0] val);
        @(negedge clk);
        wr_sel  = AW'(idx);
        wr_data = val;
        @(negedge clk);
        rw_mode = 1'b0;
        exp_q.push_back(16'h0000);
        tag_q.push_back("R3 write-mode ports");
        @(negedge clk);
        rw_mode = 1'b1;
        mem[idx] = val;
    endtask

    // Data changes while the latch is open; the last value must stick (R4)
    task automatic write_twice(input int idx, input logic [DW-1:0] v1, input logic [DW-1:0] v2);
        @(negedge clk);
        wr_sel  = AW'(idx);
        wr_data = v1;
        @(negedge clk);
        rw_mode = 1'b0;
        @(negedge clk);
        wr_data = v2;
        @(negedge clk);
        rw_mode = 1'b1;
        mem[idx] = v2;
    endtask

    task automatic sweep_primitives();
        bit seen2 [4];
        bit seen3 [8];
        bit all;
        foreach (seen2[i]) seen2[i] = 1'b0;
        for (int v = 0; v < 4; v++) begin
            {ca, cb} = 2'(v);
            #1;
            check({cp, cq} == {ca, ca ^ cb}, "R7 controlled-NOT map", 16'({cp, cq}), 16'({ca, ca ^ cb}));
            seen2[{cp, cq}] = 1'b1;
        end
        all = 1'b1;
        foreach (seen2[i]) all &= seen2[i];
        check(all, "R7 controlled-NOT bijection", 16'(all), 16'd1);

        foreach (seen3[i]) seen3[i] = 1'b0;
        for (int v = 0; v < 8; v++) begin
            {sc, sx, sy} = 3'(v);
            #1;
            check({sp, sq, sr} == {sc, sc ? sy : sx, sc ? sx : sy}, "R7 controlled-swap map",
                  16'({sp, sq, sr}), 16'({sc, sc ? sy : sx, sc ? sx : sy}));
            seen3[{sp, sq, sr}] = 1'b1;
        end
        all = 1'b1;
        foreach (seen3[i]) all &= seen3[i];
        check(all, "R7 controlled-swap bijection", 16'(all), 16'd1);

        foreach (seen3[i]) seen3[i] = 1'b0;
        for (int v = 0; v < 8; v++) begin
            {ta, tb, tc} = 3'(v);
            #1;
            check({tp, tq, tr} == {ta, tb, tc ^ (ta & tb)}, "R7 double-controlled-NOT map",
                  16'({tp, tq, tr}), 16'({ta, tb, tc ^ (ta & tb)}));
            seen3[{tp, tq, tr}] = 1'b1;
        end
        all = 1'b1;
        foreach (seen3[i]) all &= seen3[i];
        check(all, "R7 double-controlled-NOT bijection", 16'(all), 16'd1);
    endtask

    initial begin
        foreach (mem[i]) mem[i] = '0;
        sweep_primitives();

        // Start in write mode: both ports must be zero (R3)
        @(negedge clk);
        exp_q.push_back(16'h0000);
        tag_q.push_back("R3 initial write mode");
        @(negedge clk);
        rw_mode = 1'b1;

        // Fill every register with random data, read back on both ports (R1 R2 R8)
        for (int i = 0; i < NREG; i++) write_reg(i, DW'($urandom()));
        for (int i = 0; i < NREG; i++) do_read(i, NREG - 1 - i, "R1 R2 R8 readback");

        // Boundary indices and extreme patterns
        write_reg(0, 8'h00);
        write_reg(NREG - 1, 8'hFF);
        do_read(0, NREG - 1, "R1 boundary registers");
        do_read(NREG - 1, 0, "R1 boundary registers swapped");
        do_read(12, 12, "R2 same select");

        // Toggle write inputs in read mode; nothing may change (R5)
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            wr_data = DW'($urandom());
            wr_sel  = AW'($urandom());
        end
        for (int i = 0; i < NREG; i++) do_read(i, (i + 5) % NREG, "R5 hold in read mode");

        // One write leaves all neighbours alone (R6)
        write_reg(7, 8'h5A);
        for (int i = 0; i < NREG; i++) do_read(i, 7, "R6 neighbours kept");

        // Transparent while open, last value kept (R4)
        write_twice(19, 8'h3C, 8'hC3);
        do_read(19, 18, "R4 last value kept");
        write_twice(20, 8'hA5, 8'h00);
        do_read(20, 19, "R4 last value kept");

        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        #(LIMIT * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            report();
            $finish;
        end
    end
endmodule